// File: doc/BRIEF.md
# I2C Target Acquisition Entry Encoder

This block sits behind the bus-level engine of an I2C target. It turns decoded bus events into tagged 11-bit entries for the acquisition queue that software drains. The engine reports these events as one-cycle strobes: start, repeated start, a completed address byte, a received data byte, a NACK of a received byte, a NACK of the target's own address, a stop, and a bus error. The encoder then decides which events become entries, and with which format code.

A start or a repeated start is never written on its own. It is merged with the address byte that follows, and that merged entry is written only when the address matches one of the programmed address/mask pairs. The block keeps a per-transaction "addressed" flag and a sticky error flag. A closing stop entry is written only when the transaction addressed this target, and its code shows whether an error was seen. One output register holds each entry until the queue accepts it. While an entry waits, a stall output asks the engine to stretch the clock.

Top module: `i2c_acq_encoder`

## Requirements
- R1: Every entry is 11 bits: bits 10:8 hold the format code and bits 7:0 hold the payload. A start followed by a matching address byte produces one entry with code 001, carrying the address in bits 7:1 and the R/W bit in bit 0.
- R2: A repeated start followed by a matching address byte produces exactly one entry, with code 011 and the address byte as payload. No entry is produced for the repeated start by itself.
- R3: An address byte that matches neither pair produces no entry, whether it follows a start or a repeated start.
- R4: An address matches when (received & mask) equals (programmed & mask) for either of the two pairs. Pair 0 is cfg bits 6:0 and pair 1 is cfg bits 13:7.
- R5: A data byte produces an entry with code 000 and the byte as payload, but only inside a write transfer (R/W = 0) that addressed this target. Data bytes in read transfers, or in transfers to other targets, produce no entry.
- R6: A stop produces an entry with payload 0x00 only if the transaction was addressed. Otherwise a stop produces nothing.
- R7: A bus error sets a sticky flag. A stop that closes an addressed transaction then uses code 110 instead of 010. The stop clears the flag, so the next transaction closes with 010.
- R8: A repeated start to a non-matching address writes nothing. The transaction still closes with a stop entry, because the addressed flag stays set until the stop.
- R9: A NACK of a received byte inside an addressed write transfer produces code 100 with that byte as payload. A NACK of a matching address produces code 101 with the address byte as payload, and it does not set the addressed flag.
- R10: An address phase interrupted by a stop or by a new start produces no entry. An address byte with no preceding start or repeated start is ignored.
- R11: While the queue is not ready, the pending entry holds stable and stall_o is high. Each accepted entry appears exactly once.
- R12: addressed_o is low after reset. It rises in the cycle after a matching address entry and falls in the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_start_i | input | 1 | Start condition strobe |
| ev_rstart_i | input | 1 | Repeated start strobe |
| ev_addr_i | input | 1 | Address byte complete strobe |
| ev_addr_nack_i | input | 1 | Own address NACKed strobe |
| ev_data_i | input | 1 | Data byte received strobe |
| ev_nack_i | input | 1 | Received byte NACKed strobe |
| ev_stop_i | input | 1 | Stop condition strobe |
| ev_err_i | input | 1 | Bus error strobe |
| bus_byte_i | input | 8 | Byte that goes with the address, data or NACK strobes |
| cfg_addr_i | input | 14 | Programmed addresses, 7 bits per pair |
| cfg_mask_i | input | 14 | Address masks, 7 bits per pair |
| ent_valid_o | output | 1 | Entry valid toward the queue |
| ent_data_o | output | 11 | Entry: format code in 10:8, payload in 7:0 |
| ent_ready_i | input | 1 | Queue accepts the entry |
| stall_o | output | 1 | Entry waiting, clock stretch request |
| addressed_o | output | 1 | Current transaction has addressed this target |

## Verification
The assertions assume that the engine raises at most one of the start, repeated-start, address, address-NACK, data, NACK and stop strobes in any cycle. They also assume the engine raises none of these strobes while stall_o is high, since a stretched bus cannot deliver a new symbol. The bench drives one strobe per task step and holds the bus idle for the whole backpressure scenario. Each entry is checked at the port one cycle after its strobe, and the bench checks again one cycle later that no second entry appears.

// File: rtl/acq_enc_pkg.sv
package acq_enc_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FMT_W   = 3;
  localparam int unsigned ENTRY_W = FMT_W + BYTE_W;

  typedef enum logic [FMT_W-1:0] {
    FMT_DATA      = 3'b000,
    FMT_START     = 3'b001,
    FMT_STOP_OK   = 3'b010,
    FMT_RSTART    = 3'b011,
    FMT_NACK_RX   = 3'b100,
    FMT_NACK_ADDR = 3'b101,
    FMT_STOP_ERR  = 3'b110
  } fmt_e;

  typedef enum logic [1:0] {
    OPEN_NONE   = 2'd0,
    OPEN_START  = 2'd1,
    OPEN_RSTART = 2'd2
  } open_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [BYTE_W-1:0] payload;
  } entry_t;
endpackage

// File: rtl/acq_addr_match.sv
module acq_addr_match #(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned AW        = 7
) (
  input  logic [AW-1:0]           addr_i,
  input  logic [NUM_PAIRS*AW-1:0] cfg_addr_i,
  input  logic [NUM_PAIRS*AW-1:0] cfg_mask_i,
  output logic                    hit_o
);
  logic [NUM_PAIRS-1:0] pair_hit;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pair_hit[g] =
      ((addr_i ^ cfg_addr_i[g*AW +: AW]) & cfg_mask_i[g*AW +: AW]) == '0;
  end

  assign hit_o = |pair_hit;
endmodule

// File: rtl/acq_txn_tracker.sv
module acq_txn_tracker
  import acq_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_start_i,
  input  logic              ev_rstart_i,
  input  logic              ev_addr_i,
  input  logic              ev_addr_nack_i,
  input  logic              ev_data_i,
  input  logic              ev_nack_i,
  input  logic              ev_stop_i,
  input  logic              ev_err_i,
  input  logic [BYTE_W-1:0] bus_byte_i,
  input  logic              hit_i,
  output logic              push_o,
  output entry_t            entry_o,
  output logic              addressed_o
);
  open_e open_q, open_d;
  logic  addressed_q, addressed_d;
  logic  wr_xfer_q, wr_xfer_d;
  logic  err_q, err_d;

  always_comb begin
    open_d         = open_q;
    addressed_d    = addressed_q;
    wr_xfer_d      = wr_xfer_q;
    err_d          = err_q | ev_err_i;
    push_o         = 1'b0;
    entry_o.fmt    = FMT_DATA;
    entry_o.payload = bus_byte_i;
    if (ev_start_i) begin
      open_d    = OPEN_START;
      wr_xfer_d = 1'b0;
    end else if (ev_rstart_i) begin
      open_d    = OPEN_RSTART;
      wr_xfer_d = 1'b0;
    end else if (ev_addr_i) begin
      if (open_q != OPEN_NONE && hit_i) begin
        push_o      = 1'b1;
        entry_o.fmt = (open_q == OPEN_RSTART) ? FMT_RSTART : FMT_START;
        addressed_d = 1'b1;
        wr_xfer_d   = ~bus_byte_i[0];
      end
      open_d = OPEN_NONE;
    end else if (ev_addr_nack_i) begin
      if (open_q != OPEN_NONE && hit_i) begin
        push_o      = 1'b1;
        entry_o.fmt = FMT_NACK_ADDR;
      end
      open_d    = OPEN_NONE;
      wr_xfer_d = 1'b0;
    end else if (ev_data_i) begin
      push_o = wr_xfer_q;
    end else if (ev_nack_i) begin
      push_o      = wr_xfer_q;
      entry_o.fmt = FMT_NACK_RX;
      wr_xfer_d   = 1'b0;
    end else if (ev_stop_i) begin
      push_o          = addressed_q;
      entry_o.fmt     = (err_q | ev_err_i) ? FMT_STOP_ERR : FMT_STOP_OK;
      entry_o.payload = '0;
      open_d          = OPEN_NONE;
      addressed_d     = 1'b0;
      wr_xfer_d       = 1'b0;
      err_d           = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= OPEN_NONE;
      addressed_q <= 1'b0;
      wr_xfer_q   <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      open_q      <= open_d;
      addressed_q <= addressed_d;
      wr_xfer_q   <= wr_xfer_d;
      err_q       <= err_d;
    end
  end

  assign addressed_o = addressed_q;

  // Input assumption: the engine reports one bus symbol per cycle (R10).
  p_single_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_start_i, ev_rstart_i, ev_addr_i, ev_addr_nack_i,
              ev_data_i, ev_nack_i, ev_stop_i}));

  // A stop always drops the addressed flag (R12).
  p_clear_on_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop_i |=> !addressed_q);
endmodule

// File: rtl/acq_out_slot.sv
module acq_out_slot
  import acq_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  entry_t             entry_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [ENTRY_W-1:0] data_o,
  output logic               stall_o
);
  logic               valid_q, valid_d;
  logic [ENTRY_W-1:0] data_q, data_d;
  logic               load_en;

  assign load_en = push_i;

  always_comb begin
    valid_d = push_i | (valid_q & ~ready_i);
    data_d  = load_en ? entry_i : data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) data_q <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign stall_o = valid_q & ~ready_i;

  // A waiting entry is neither changed nor lost (R11).
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));

  // No new entry while one is stalled: nothing would be dropped (R11).
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !stall_o);

  // A pushed entry shows at the port in the next cycle (R11).
  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (valid_q && data_q == $past(entry_i)));
endmodule

// File: rtl/i2c_acq_encoder.sv
module i2c_acq_encoder
  import acq_enc_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ev_start_i,
  input  logic                        ev_rstart_i,
  input  logic                        ev_addr_i,
  input  logic                        ev_addr_nack_i,
  input  logic                        ev_data_i,
  input  logic                        ev_nack_i,
  input  logic                        ev_stop_i,
  input  logic                        ev_err_i,
  input  logic [7:0]                  bus_byte_i,
  input  logic [NUM_PAIRS*ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_PAIRS*ADDR_W-1:0] cfg_mask_i,
  output logic                        ent_valid_o,
  output logic [ENTRY_W-1:0]          ent_data_o,
  input  logic                        ent_ready_i,
  output logic                        stall_o,
  output logic                        addressed_o
);
  logic   hit;
  logic   push;
  entry_t entry;

  acq_addr_match #(.NUM_PAIRS(NUM_PAIRS), .AW(ADDR_W)) u_match (
    .addr_i     (bus_byte_i[BYTE_W-1:1]),
    .cfg_addr_i (cfg_addr_i),
    .cfg_mask_i (cfg_mask_i),
    .hit_o      (hit)
  );

  acq_txn_tracker u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ev_start_i     (ev_start_i),
    .ev_rstart_i    (ev_rstart_i),
    .ev_addr_i      (ev_addr_i),
    .ev_addr_nack_i (ev_addr_nack_i),
    .ev_data_i      (ev_data_i),
    .ev_nack_i      (ev_nack_i),
    .ev_stop_i      (ev_stop_i),
    .ev_err_i       (ev_err_i),
    .bus_byte_i     (bus_byte_i),
    .hit_i          (hit),
    .push_o         (push),
    .entry_o        (entry),
    .addressed_o    (addressed_o)
  );

  acq_out_slot u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .entry_i (entry),
    .ready_i (ent_ready_i),
    .valid_o (ent_valid_o),
    .data_o  (ent_data_o),
    .stall_o (stall_o)
  );

  // A fresh repeated-start entry comes from an address byte (R2).
  p_rstart_from_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && ent_data_o[10:8] == 3'b011 && !$past(stall_o))
      |-> $past(ev_addr_i));

  // Stop entries carry a zero payload (R6).
  p_stop_payload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && (ent_data_o[10:8] == 3'b010 || ent_data_o[10:8] == 3'b110))
      |-> ent_data_o[7:0] == 8'h00);
endmodule

// File: tb/i2c_acq_encoder_test.sv
module i2c_acq_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 0, ev_rstart = 0, ev_addr = 0, ev_addr_nack = 0;
  logic        ev_data = 0, ev_nack = 0, ev_stop = 0, ev_err = 0;
  logic [7:0]  bus_byte = 8'h00;
  logic [13:0] cfg_addr, cfg_mask;
  logic        ent_valid;
  logic [10:0] ent_data;
  logic        ent_ready = 1'b1;
  logic        stall, addressed;
  int          errors = 0;
  int          checks = 0;

  // Pair 0: 0x50 exact. Pair 1: 0x20 with mask 0x70 (0x20..0x2F).
  assign cfg_addr = {7'h20, 7'h50};
  assign cfg_mask = {7'h70, 7'h7F};

  always #4 clk = ~clk;

  i2c_acq_encoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_start_i(ev_start), .ev_rstart_i(ev_rstart), .ev_addr_i(ev_addr),
    .ev_addr_nack_i(ev_addr_nack), .ev_data_i(ev_data), .ev_nack_i(ev_nack),
    .ev_stop_i(ev_stop), .ev_err_i(ev_err), .bus_byte_i(bus_byte),
    .cfg_addr_i(cfg_addr), .cfg_mask_i(cfg_mask),
    .ent_valid_o(ent_valid), .ent_data_o(ent_data), .ent_ready_i(ent_ready),
    .stall_o(stall), .addressed_o(addressed)
  );

  typedef enum {E_START, E_RSTART, E_ADDR, E_ADDR_NACK, E_DATA, E_NACK, E_STOP, E_ERR} ev_e;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse one event for one cycle; sample the port one cycle later.
  task automatic pulse(ev_e e, logic [7:0] b);
    @(negedge clk);
    bus_byte = b;
    case (e)
      E_START:     ev_start = 1;
      E_RSTART:    ev_rstart = 1;
      E_ADDR:      ev_addr = 1;
      E_ADDR_NACK: ev_addr_nack = 1;
      E_DATA:      ev_data = 1;
      E_NACK:      ev_nack = 1;
      E_STOP:      ev_stop = 1;
      E_ERR:       ev_err = 1;
    endcase
    @(negedge clk);
    {ev_start, ev_rstart, ev_addr, ev_addr_nack, ev_data, ev_nack, ev_stop, ev_err} = '0;
  endtask

  task automatic expect_entry(string req, ev_e e, logic [7:0] b, logic [10:0] exp);
    pulse(e, b);
    check(req, {20'h0, ent_valid, ent_data}, {20'h0, 1'b1, exp});
  endtask

  task automatic expect_none(string req, ev_e e, logic [7:0] b);
    pulse(e, b);
    check(req, {31'h0, ent_valid}, 32'h0);
  endtask

  task automatic t_reset;
    check("R12 reset addressed", {31'h0, addressed}, 0);
    check("R11 reset valid/stall", {30'h0, ent_valid, stall}, 0);
  endtask

  task automatic t_write;
    pulse(E_START, 8'h00);
    check("R10 start alone", {31'h0, ent_valid}, 0);
    expect_entry("R1 start+addr", E_ADDR, 8'hA0, 11'b001_1010_0000);
    check("R12 addressed set", {31'h0, addressed}, 1);
    expect_entry("R5 data 3C", E_DATA, 8'h3C, 11'h03C);
    expect_entry("R5 data 00", E_DATA, 8'h00, 11'h000);
    expect_entry("R6 stop ok", E_STOP, 8'hFF, 11'b010_0000_0000);
    check("R12 addressed clear", {31'h0, addressed}, 0);
  endtask

  task automatic t_read;
    pulse(E_START, 8'h00);
    expect_entry("R1 read addr", E_ADDR, 8'hA1, 11'b001_1010_0001);
    expect_none("R5 read data ignored", E_DATA, 8'h77);
    expect_entry("R6 read stop", E_STOP, 8'h00, 11'b010_0000_0000);
  endtask

  task automatic t_nomatch;
    pulse(E_START, 8'h00);
    expect_none("R3 addr 0x30", E_ADDR, 8'h60);
    expect_none("R5 foreign data", E_DATA, 8'h12);
    expect_none("R6 stop unaddressed", E_STOP, 8'h00);
    pulse(E_START, 8'h00);
    expect_none("R4 addr 0x51", E_ADDR, 8'hA2);
    expect_none("R6 stop unaddressed 2", E_STOP, 8'h00);
    pulse(E_START, 8'h00);
    expect_entry("R4 masked pair1 0x2A", E_ADDR, 8'h54, 11'b001_0101_0100);
    expect_entry("R6 stop pair1", E_STOP, 8'h00, 11'b010_0000_0000);
  endtask

  task automatic t_rstart;
    pulse(E_START, 8'h00);
    expect_entry("R1 addr", E_ADDR, 8'hA0, 11'h1A0);
    expect_entry("R5 data", E_DATA, 8'h11, 11'h011);
    expect_none("R2 rstart alone", E_RSTART, 8'h00);
    expect_entry("R2 rstart+addr", E_ADDR, 8'hA1, 11'b011_1010_0001);
    @(negedge clk);
    check("R2 single entry", {31'h0, ent_valid}, 0);
    expect_entry("R6 stop", E_STOP, 8'h00, 11'h200);
  endtask

  task automatic t_defer;
    pulse(E_START, 8'h00);
    expect_entry("R1 addr", E_ADDR, 8'hA0, 11'h1A0);
    expect_entry("R5 data", E_DATA, 8'h22, 11'h022);
    pulse(E_RSTART, 8'h00);
    expect_none("R3 rstart foreign", E_ADDR, 8'h60);
    expect_none("R8 foreign data", E_DATA, 8'h33);
    check("R8 still addressed", {31'h0, addressed}, 1);
    expect_entry("R8 deferred close", E_STOP, 8'h00, 11'h200);
  endtask

  task automatic t_err;
    pulse(E_START, 8'h00);
    expect_entry("R1 addr", E_ADDR, 8'hA0, 11'h1A0);
    expect_none("R7 err no entry", E_ERR, 8'h00);
    expect_entry("R5 data", E_DATA, 8'h44, 11'h044);
    expect_entry("R7 error stop", E_STOP, 8'h00, 11'b110_0000_0000);
    pulse(E_START, 8'h00);
    expect_entry("R1 addr", E_ADDR, 8'hA0, 11'h1A0);
    expect_entry("R7 flag cleared", E_STOP, 8'h00, 11'h200);
  endtask

  task automatic t_nack;
    pulse(E_START, 8'h00);
    expect_entry("R1 addr", E_ADDR, 8'hA0, 11'h1A0);
    expect_entry("R9 rx nack", E_NACK, 8'h99, 11'b100_1001_1001);
    expect_entry("R6 stop", E_STOP, 8'h00, 11'h200);
    pulse(E_START, 8'h00);
    expect_entry("R9 addr nack", E_ADDR_NACK, 8'hA0, 11'b101_1010_0000);
    check("R9 nack not addressed", {31'h0, addressed}, 0);
    expect_none("R9 stop after addr nack", E_STOP, 8'h00);
  endtask

  task automatic t_interrupt;
    pulse(E_START, 8'h00);
    expect_none("R10 stop before addr", E_STOP, 8'h00);
    expect_none("R10 addr without start", E_ADDR, 8'hA0);
    pulse(E_START, 8'h00);
    pulse(E_START, 8'h00);
    expect_entry("R10 restarted addr", E_ADDR, 8'hA0, 11'h1A0);
    @(negedge clk);
    check("R10 one entry", {31'h0, ent_valid}, 0);
    expect_entry("R6 stop", E_STOP, 8'h00, 11'h200);
  endtask

  task automatic t_stall;
    pulse(E_START, 8'h00);
    @(negedge clk);
    ent_ready = 1'b0;
    pulse(E_ADDR, 8'hA0);
    for (int i = 0; i < 4; i++) begin
      check("R11 held entry", {20'h0, ent_valid, ent_data}, {20'h0, 1'b1, 11'h1A0});
      check("R11 stall", {31'h0, stall}, 1);
      @(negedge clk);
    end
    ent_ready = 1'b1;
    #1;
    check("R11 stall drops on ready", {31'h0, stall}, 0);
    @(negedge clk);
    check("R11 no duplicate", {31'h0, ent_valid}, 0);
    expect_entry("R6 stop after stall", E_STOP, 8'h00, 11'h200);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write();
    t_read();
    t_nomatch();
    t_rstart();
    t_defer();
    t_err();
    t_nack();
    t_interrupt();
    t_stall();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule